// File: doc/BRIEF.md
# Link Training Sequencer

This block drives the two-phase training of a multi-lane serial display link. After a start pulse it runs clock recovery, in which the receiver is asked to lock onto a simple pattern while the transmit drive levels are raised as the receiver requests. It then runs channel equalization with a richer pattern, reporting pass or fail for each phase. Each drive setting is a 2-bit voltage swing level (0.4, 0.6, 0.8, 1.2 V) and a 2-bit pre-emphasis level (0, 3.5, 6, 9.5 dB). One combined setting is applied to all lanes.

The sink is reached through an abstract register-access port with three targets: training pattern, drive setting and lane status. Each access is a request that is held until a one-cycle done pulse. On the source side the block drives the pattern and drive levels of the local transmitter directly. Link rate, lane count selection and the transport underneath the access port are handled elsewhere. The wait before each status poll is set by the `poll_wait` input. The fixed settle waits at the start of clock recovery and at the finish come from a parameter.

Top module: `lt_train_seq`

## Requirements
- R1: After reset `busy`, `train_done`, `cr_ok`, `eq_ok` are 0, `src_pattern`, `src_swing`, `src_pre` are 0 and neither `acc_wr` nor `acc_rd` is asserted.
- R2: An access request (`acc_wr` or `acc_rd`, never both) stays asserted with stable `acc_addr` and `acc_wdata` until `acc_done`. Address codes: 0 = pattern (wdata[1:0] holds the pattern number, 0 = off), 1 = drive setting, 2 = status read.
- R3: On `start` the source pattern becomes 1 and the drive levels become 0. The sink is written pattern 1 and then an all-zero drive word. The first status read is issued no earlier than SETTLE_CYCLES + `poll_wait` cycles after that drive write completes.
- R4: Status word: lane i occupies bits [6i+5:6i], with [1:0] requested swing, [3:2] requested pre-emphasis, [4] clock locked, [5] equalized. Lanes with index >= `lane_cnt` are ignored. The next setting uses the maximum requested swing and the maximum requested pre-emphasis over the active lanes.
- R5: A drive word holds the same 6-bit field for every lane: [1:0] swing, [2] max-swing flag (set when swing is 3), [4:3] pre-emphasis, [5] max-pre-emphasis flag (set when pre-emphasis is 3). `src_swing`/`src_pre` equal the last setting written.
- R6: Clock recovery passes when every active lane reports lock. `cr_ok` is then set and equalization begins.
- R7: Clock recovery fails, without a further adjustment, when the current setting already carries the max-swing flag and lock is missing.
- R8: In clock recovery a try counter increments when the current swing equals the swing of the previous iteration and clears otherwise. The phase fails when it would reach 5, so a constant swing-0 request fails at the sixth status read.
- R9: Equalization uses pattern 3 when `tps3_ok` is high at start and pattern 2 otherwise. It passes, setting `eq_ok`, when every active lane reports both lock and equalized.
- R10: Equalization fails when a poll finds it not passed after more than 5 adjustments, which is the seventh equalization status read.
- R11: A status read completing with `acc_ok` low ends the current phase as failed.
- R12: Whether training passed or failed, after SETTLE_CYCLES the sink pattern is written 0, then the source pattern goes to 0 and `train_done` is set. `train_done`, `cr_ok` and `eq_ok` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (taken when idle) |
| lane_cnt | input | 3 | Number of active lanes (1 to 4) |
| tps3_ok | input | 1 | Sink supports pattern 3 |
| poll_wait | input | 16 | Cycles to wait before each status poll |
| acc_wr | output | 1 | Write request to the sink |
| acc_rd | output | 1 | Read request to the sink |
| acc_addr | output | 2 | Access target: 0 pattern, 1 drive, 2 status |
| acc_wdata | output | 24 | Write data |
| acc_done | input | 1 | One-cycle completion of the current access |
| acc_ok | input | 1 | Read completed without error |
| acc_rdata | input | 24 | Status read data |
| src_pattern | output | 2 | Source training pattern, 0 = off |
| src_swing | output | 2 | Source swing level |
| src_pre | output | 2 | Source pre-emphasis level |
| busy | output | 1 | Training in progress |
| train_done | output | 1 | Run finished |
| cr_ok | output | 1 | Clock recovery passed |
| eq_ok | output | 1 | Channel equalization passed |

## Verification
A wrong try counter or stale previous-swing value shows up as a status-read count that differs from the expected count for that run. That count is known exactly for each stimulus, so it is visible the moment `train_done` rises. A wrong lane mask or wrong maximum shows in the next drive word written to the sink, one access after the status read that caused it. A stuck pattern or a finish step skipped on failure shows as a non-zero final sink pattern or source pattern when `train_done` is set.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int LANE_W = 6;
    localparam logic [1:0] LVL_TOP = 2'd3;

    typedef enum logic [1:0] {
        ACC_PATTERN = 2'd0,
        ACC_DRIVE   = 2'd1,
        ACC_STATUS  = 2'd2
    } acc_addr_e;

    typedef enum logic [1:0] {
        PAT_OFF   = 2'd0,
        PAT_ONE   = 2'd1,
        PAT_TWO   = 2'd2,
        PAT_THREE = 2'd3
    } pattern_e;

    // per-lane drive field, same layout for every lane
    typedef struct packed {
        logic       max_pre;
        logic [1:0] pre;
        logic       max_swing;
        logic [1:0] swing;
    } drive_t;

    // per-lane status field returned by the sink
    typedef struct packed {
        logic       eq_done;
        logic       locked;
        logic [1:0] pre_req;
        logic [1:0] swing_req;
    } lane_stat_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CR_PAT,
        S_CR_DRV0,
        S_CR_SETTLE,
        S_CR_WAIT,
        S_CR_READ,
        S_CR_EVAL,
        S_CR_DRV,
        S_EQ_PAT,
        S_EQ_WAIT,
        S_EQ_READ,
        S_EQ_EVAL,
        S_EQ_DRV,
        S_FIN_SETTLE,
        S_FIN_PAT
    } seq_st_e;

    function automatic drive_t make_drive(input logic [1:0] sw, input logic [1:0] pe);
        drive_t d;
        d.swing     = sw;
        d.pre       = pe;
        d.max_swing = (sw == LVL_TOP);
        d.max_pre   = (pe == LVL_TOP);
        return d;
    endfunction

endpackage

// File: rtl/lt_lane_merge.sv
module lt_lane_merge
    import lt_pkg::*;
#(
    parameter int MAX_LANES = 4,
    parameter int CNT_W     = 3
) (
    input  logic [LANE_W*MAX_LANES-1:0] stat,
    input  logic [CNT_W-1:0]            lane_cnt,
    output drive_t                      nxt_drive,
    output logic                        all_lock,
    output logic                        all_eq
);

    logic [MAX_LANES-1:0] lk_ok;
    logic [MAX_LANES-1:0] eq_ok_v;
    logic [1:0]           sw_req [MAX_LANES];
    logic [1:0]           pe_req [MAX_LANES];
    logic [1:0]           sw_max;
    logic [1:0]           pe_max;

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        lane_stat_t ls;
        logic       act;
        assign ls         = lane_stat_t'(stat[LANE_W*i +: LANE_W]);
        assign act        = (CNT_W'(i) < lane_cnt);
        assign sw_req[i]  = act ? ls.swing_req : 2'd0;
        assign pe_req[i]  = act ? ls.pre_req   : 2'd0;
        assign lk_ok[i]   = ls.locked | ~act;
        assign eq_ok_v[i] = (ls.locked & ls.eq_done) | ~act;
    end

    always_comb begin
        sw_max = 2'd0;
        pe_max = 2'd0;
        for (int i = 0; i < MAX_LANES; i++) begin
            if (sw_req[i] > sw_max) sw_max = sw_req[i];
            if (pe_req[i] > pe_max) pe_max = pe_req[i];
        end
    end

    assign nxt_drive = make_drive(sw_max, pe_max);
    assign all_lock  = &lk_ok;
    assign all_eq    = &eq_ok_v;

endmodule

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/lt_seq.sv
module lt_seq
    import lt_pkg::*;
#(
    parameter int MAX_LANES     = 4,
    parameter int WAIT_W        = 16,
    parameter int SETTLE_CYCLES = 400,
    parameter int CR_TRIES      = 5,
    parameter int EQ_TRIES      = 5,
    parameter int TRY_W         = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        tps3_ok,
    input  logic [WAIT_W-1:0]           poll_wait,
    input  logic                        acc_done,
    input  logic                        acc_ok,
    input  logic [LANE_W*MAX_LANES-1:0] acc_rdata,
    input  drive_t                      nxt_drive,
    input  logic                        all_lock,
    input  logic                        all_eq,
    input  logic                        tmr_expired,
    output logic                        tmr_load,
    output logic [WAIT_W-1:0]           tmr_val,
    output logic [LANE_W*MAX_LANES-1:0] stat_q,
    output logic                        acc_wr,
    output logic                        acc_rd,
    output logic [1:0]                  acc_addr,
    output logic [LANE_W*MAX_LANES-1:0] acc_wdata,
    output logic [1:0]                  src_pattern,
    output logic [1:0]                  src_swing,
    output logic [1:0]                  src_pre,
    output logic                        busy,
    output logic                        train_done,
    output logic                        cr_ok,
    output logic                        eq_ok
);

    localparam int DW = LANE_W*MAX_LANES;
    localparam logic [WAIT_W-1:0] SETTLE_V = WAIT_W'(SETTLE_CYCLES);
    localparam logic [TRY_W-1:0]  CR_LAST  = TRY_W'(CR_TRIES - 1);
    localparam logic [TRY_W-1:0]  EQ_LIM   = TRY_W'(EQ_TRIES);

    seq_st_e          st, st_n;
    drive_t           drv;
    logic [TRY_W-1:0] tries;
    logic [1:0]       prev_sw;
    logic             prev_vld;
    logic             tps3_q;
    pattern_e         src_pat;
    logic             cr_ok_q, eq_ok_q, done_q;
    logic             cr_same, cr_exhaust;
    pattern_e         eq_pat;

    assign cr_same    = prev_vld && (drv.swing == prev_sw);
    assign cr_exhaust = cr_same && (tries == CR_LAST);
    assign eq_pat     = tps3_q ? PAT_THREE : PAT_TWO;

    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:       if (start)       st_n = S_CR_PAT;
            S_CR_PAT:     if (acc_done)    st_n = S_CR_DRV0;
            S_CR_DRV0:    if (acc_done)    st_n = S_CR_SETTLE;
            S_CR_SETTLE:  if (tmr_expired) st_n = S_CR_WAIT;
            S_CR_WAIT:    if (tmr_expired) st_n = S_CR_READ;
            S_CR_READ:    if (acc_done)    st_n = acc_ok ? S_CR_EVAL : S_FIN_SETTLE;
            S_CR_EVAL: begin
                if (all_lock)                          st_n = S_EQ_PAT;
                else if (drv.max_swing || cr_exhaust)  st_n = S_FIN_SETTLE;
                else                                   st_n = S_CR_DRV;
            end
            S_CR_DRV:     if (acc_done)    st_n = S_CR_WAIT;
            S_EQ_PAT:     if (acc_done)    st_n = S_EQ_WAIT;
            S_EQ_WAIT:    if (tmr_expired) st_n = S_EQ_READ;
            S_EQ_READ:    if (acc_done)    st_n = acc_ok ? S_EQ_EVAL : S_FIN_SETTLE;
            S_EQ_EVAL: begin
                if (all_eq)               st_n = S_FIN_SETTLE;
                else if (tries > EQ_LIM)  st_n = S_FIN_SETTLE;
                else                      st_n = S_EQ_DRV;
            end
            S_EQ_DRV:     if (acc_done)    st_n = S_EQ_WAIT;
            S_FIN_SETTLE: if (tmr_expired) st_n = S_FIN_PAT;
            S_FIN_PAT:    if (acc_done)    st_n = S_IDLE;
            default:                       st_n = S_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = poll_wait;
        if (st_n != st) begin
            unique case (st_n)
                S_CR_SETTLE, S_FIN_SETTLE: begin tmr_load = 1'b1; tmr_val = SETTLE_V; end
                S_CR_WAIT, S_EQ_WAIT:      begin tmr_load = 1'b1; tmr_val = poll_wait; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            drv      <= '0;
            tries    <= '0;
            prev_sw  <= '0;
            prev_vld <= 1'b0;
            tps3_q   <= 1'b0;
            src_pat  <= PAT_OFF;
            cr_ok_q  <= 1'b0;
            eq_ok_q  <= 1'b0;
            done_q   <= 1'b0;
            stat_q   <= '0;
        end else begin
            st <= st_n;
            unique case (st)
                S_IDLE: if (start) begin
                    src_pat  <= PAT_ONE;
                    drv      <= '0;
                    tries    <= '0;
                    prev_vld <= 1'b0;
                    tps3_q   <= tps3_ok;
                    cr_ok_q  <= 1'b0;
                    eq_ok_q  <= 1'b0;
                    done_q   <= 1'b0;
                end
                S_CR_READ, S_EQ_READ: if (acc_done) stat_q <= acc_rdata;
                S_CR_EVAL: begin
                    if (all_lock) begin
                        cr_ok_q <= 1'b1;
                        tries   <= '0;
                        src_pat <= eq_pat;
                    end else if (!drv.max_swing && !cr_exhaust) begin
                        tries    <= cr_same ? tries + TRY_W'(1) : '0;
                        prev_sw  <= drv.swing;
                        prev_vld <= 1'b1;
                        drv      <= nxt_drive;
                    end
                end
                S_EQ_EVAL: begin
                    if (all_eq) begin
                        eq_ok_q <= 1'b1;
                    end else if (tries <= EQ_LIM) begin
                        drv   <= nxt_drive;
                        tries <= tries + TRY_W'(1);
                    end
                end
                S_FIN_PAT: if (acc_done) begin
                    src_pat <= PAT_OFF;
                    done_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        acc_wr    = 1'b0;
        acc_rd    = 1'b0;
        acc_addr  = ACC_PATTERN;
        acc_wdata = '0;
        unique case (st)
            S_CR_PAT: begin
                acc_wr    = 1'b1;
                acc_wdata = DW'(PAT_ONE);
            end
            S_EQ_PAT: begin
                acc_wr    = 1'b1;
                acc_wdata = DW'(eq_pat);
            end
            S_FIN_PAT: begin
                acc_wr    = 1'b1;
                acc_wdata = DW'(PAT_OFF);
            end
            S_CR_DRV0, S_CR_DRV, S_EQ_DRV: begin
                acc_wr    = 1'b1;
                acc_addr  = ACC_DRIVE;
                acc_wdata = {MAX_LANES{drv}};
            end
            S_CR_READ, S_EQ_READ: begin
                acc_rd   = 1'b1;
                acc_addr = ACC_STATUS;
            end
            default: ;
        endcase
    end

    assign src_pattern = src_pat;
    assign src_swing   = drv.swing;
    assign src_pre     = drv.pre;
    assign busy        = (st != S_IDLE);
    assign train_done  = done_q;
    assign cr_ok       = cr_ok_q;
    assign eq_ok       = eq_ok_q;

endmodule

// File: rtl/lt_train_seq.sv
module lt_train_seq
    import lt_pkg::*;
#(
    parameter int MAX_LANES     = 4,
    parameter int WAIT_W        = 16,
    parameter int SETTLE_CYCLES = 400,
    parameter int CR_TRIES      = 5,
    parameter int EQ_TRIES      = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [$clog2(MAX_LANES+1)-1:0]     lane_cnt,
    input  logic                               tps3_ok,
    input  logic [WAIT_W-1:0]                  poll_wait,
    output logic                               acc_wr,
    output logic                               acc_rd,
    output logic [1:0]                         acc_addr,
    output logic [6*MAX_LANES-1:0]             acc_wdata,
    input  logic                               acc_done,
    input  logic                               acc_ok,
    input  logic [6*MAX_LANES-1:0]             acc_rdata,
    output logic [1:0]                         src_pattern,
    output logic [1:0]                         src_swing,
    output logic [1:0]                         src_pre,
    output logic                               busy,
    output logic                               train_done,
    output logic                               cr_ok,
    output logic                               eq_ok
);

    localparam int CNT_W   = $clog2(MAX_LANES + 1);
    localparam int DW      = LANE_W * MAX_LANES;
    localparam int TRY_MAX = (CR_TRIES > EQ_TRIES) ? CR_TRIES : EQ_TRIES;
    localparam int TRY_W   = $clog2(TRY_MAX + 2);

    drive_t            nxt_drive;
    logic              all_lock, all_eq;
    logic              tmr_load, tmr_expired;
    logic [WAIT_W-1:0] tmr_val;
    logic [DW-1:0]     stat_q;

    lt_lane_merge #(
        .MAX_LANES (MAX_LANES),
        .CNT_W     (CNT_W)
    ) u_merge (
        .stat      (stat_q),
        .lane_cnt  (lane_cnt),
        .nxt_drive (nxt_drive),
        .all_lock  (all_lock),
        .all_eq    (all_eq)
    );

    lt_wait_timer #(
        .W (WAIT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lt_seq #(
        .MAX_LANES     (MAX_LANES),
        .WAIT_W        (WAIT_W),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .CR_TRIES      (CR_TRIES),
        .EQ_TRIES      (EQ_TRIES),
        .TRY_W         (TRY_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .tps3_ok     (tps3_ok),
        .poll_wait   (poll_wait),
        .acc_done    (acc_done),
        .acc_ok      (acc_ok),
        .acc_rdata   (acc_rdata),
        .nxt_drive   (nxt_drive),
        .all_lock    (all_lock),
        .all_eq      (all_eq),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .stat_q      (stat_q),
        .acc_wr      (acc_wr),
        .acc_rd      (acc_rd),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .src_pattern (src_pattern),
        .src_swing   (src_swing),
        .src_pre     (src_pre),
        .busy        (busy),
        .train_done  (train_done),
        .cr_ok       (cr_ok),
        .eq_ok       (eq_ok)
    );

endmodule

// File: rtl/lt_train_chk.sv
module lt_train_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          acc_wr,
    input logic          acc_rd,
    input logic [1:0]    acc_addr,
    input logic [DW-1:0] acc_wdata,
    input logic          acc_done,
    input logic [1:0]    src_pattern,
    input logic [1:0]    src_swing,
    input logic [1:0]    src_pre,
    input logic          train_done,
    input logic          cr_ok,
    input logic          eq_ok
);

    p_rw_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(acc_wr && acc_rd));

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_wr || acc_rd) && !acc_done |=>
            (acc_wr || acc_rd) && $stable(acc_addr) && $stable(acc_wdata));

    p_start_cr_r3: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> src_pattern == 2'd1 && src_swing == 2'd0 && src_pre == 2'd0);

    p_drive_flags_r5: assert property (@(posedge clk) disable iff (rst)
        acc_wr && acc_addr == 2'd1 |->
            (acc_wdata[2] == (acc_wdata[1:0] == 2'b11)) &&
            (acc_wdata[5] == (acc_wdata[4:3] == 2'b11)));

    p_eq_needs_cr_r6: assert property (@(posedge clk) disable iff (rst)
        eq_ok |-> cr_ok);

    p_eq_pattern_r9: assert property (@(posedge clk) disable iff (rst)
        acc_wr && acc_addr == 2'd0 && acc_wdata[1] |-> cr_ok);

    p_finish_off_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(train_done) |-> src_pattern == 2'd0 && !busy);

endmodule

bind lt_train_seq lt_train_chk #(.DW(6*MAX_LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .acc_wr      (acc_wr),
    .acc_rd      (acc_rd),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .acc_done    (acc_done),
    .src_pattern (src_pattern),
    .src_swing   (src_swing),
    .src_pre     (src_pre),
    .train_done  (train_done),
    .cr_ok       (cr_ok),
    .eq_ok       (eq_ok)
);

// File: tb/lt_train_seq_tb.sv
module lt_train_seq_tb;

    localparam int SETTLE = 40;
    localparam int POLL   = 5;

    typedef struct packed {
        logic [2:0] lanes;
        logic       tps3;
        logic [3:0] lock_at;
        logic [3:0] eq_at;
        logic [3:0] rdfail;
        logic [5:0] r0, r1, r2, r3;
        logic       exp_cr;
        logic       exp_eq;
        logic [3:0] exp_reads;
        logic [1:0] exp_eqpat;
        logic [5:0] exp_drv;
    } vec_t;

    // lanes tps3 lock eq fail | lane requests | cr eq reads eqpat drive
    localparam vec_t VECS [8] = '{
        '{3'd4, 1'b0, 4'd1, 4'd2, 4'd0, 6'h00, 6'h00, 6'h00, 6'h00, 1'b1, 1'b1, 4'd2, 2'd2, 6'h00}, // R6 R9 quick pass
        '{3'd2, 1'b1, 4'd3, 4'd5, 4'd0, 6'h01, 6'h06, 6'h03, 6'h03, 1'b1, 1'b1, 4'd5, 2'd3, 6'h0A}, // R4 masked max
        '{3'd1, 1'b0, 4'd0, 4'd0, 4'd0, 6'h00, 6'h0F, 6'h0F, 6'h0F, 1'b0, 1'b0, 4'd6, 2'd0, 6'h00}, // R8 constant swing
        '{3'd4, 1'b0, 4'd0, 4'd0, 4'd0, 6'h03, 6'h03, 6'h03, 6'h03, 1'b0, 1'b0, 4'd2, 2'd0, 6'h07}, // R7 max swing
        '{3'd4, 1'b1, 4'd1, 4'd0, 4'd0, 6'h0D, 6'h0D, 6'h0D, 6'h0D, 1'b1, 1'b0, 4'd8, 2'd3, 6'h39}, // R10 eq timeout
        '{3'd4, 1'b0, 4'd0, 4'd0, 4'd2, 6'h01, 6'h01, 6'h01, 6'h01, 1'b0, 1'b0, 4'd2, 2'd0, 6'h01}, // R11 in clock recovery
        '{3'd4, 1'b0, 4'd1, 4'd0, 4'd2, 6'h00, 6'h00, 6'h00, 6'h00, 1'b1, 1'b0, 4'd2, 2'd2, 6'h00}, // R11 in equalization
        '{3'd4, 1'b0, 4'd0, 4'd0, 4'd0, 6'h01, 6'h01, 6'h01, 6'h01, 1'b0, 1'b0, 4'd7, 2'd0, 6'h01}  // R8 counter clears on change
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  lane_cnt = 3'd4;
    logic        tps3_ok = 1'b0;
    logic [15:0] poll_wait = 16'(POLL);
    logic        acc_wr, acc_rd;
    logic [1:0]  acc_addr;
    logic [23:0] acc_wdata;
    logic        acc_done, acc_ok;
    logic [23:0] acc_rdata;
    logic [1:0]  src_pattern, src_swing, src_pre;
    logic        busy, train_done, cr_ok, eq_ok;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lt_train_seq #(.SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .lane_cnt(lane_cnt), .tps3_ok(tps3_ok),
        .poll_wait(poll_wait), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_ok(acc_ok), .acc_rdata(acc_rdata),
        .src_pattern(src_pattern), .src_swing(src_swing), .src_pre(src_pre), .busy(busy),
        .train_done(train_done), .cr_ok(cr_ok), .eq_ok(eq_ok)
    );

    // ---------------- sink model ----------------
    vec_t        cur;
    logic        log_clr = 1'b0;
    logic [1:0]  lat;
    int          cyc;
    int          rd_n, drv_n;
    logic [1:0]  pat_last, eqpat_log, first_pat, src_at_first;
    logic        first_pat_seen, rd_seen, fin_seen, drop_err;
    logic [23:0] drv_last;
    int          t_drv0, t_rd0, t_lastrd, t_fin;

    function automatic logic [23:0] mk_status(input int k);
        logic [23:0] s;
        logic [5:0]  rq [4];
        rq[0] = cur.r0; rq[1] = cur.r1; rq[2] = cur.r2; rq[3] = cur.r3;
        s = '0;
        for (int i = 0; i < 4; i++) begin
            s[6*i +: 4] = rq[i][3:0];
            if (i < int'(cur.lanes)) begin
                if (cur.lock_at != 0 && k >= int'(cur.lock_at)) s[6*i+4] = 1'b1;
                if (cur.eq_at   != 0 && k >= int'(cur.eq_at))   s[6*i+5] = 1'b1;
            end
        end
        return s;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || log_clr) begin
            acc_done <= 1'b0; acc_ok <= 1'b0; acc_rdata <= '0; lat <= 2'd0;
            rd_n <= 0; drv_n <= 0; pat_last <= 2'd3; eqpat_log <= 2'd0;
            first_pat <= 2'd0; src_at_first <= 2'd0; first_pat_seen <= 1'b0;
            rd_seen <= 1'b0; fin_seen <= 1'b0; drop_err <= 1'b0; drv_last <= '1;
            t_drv0 <= 0; t_rd0 <= 0; t_lastrd <= 0; t_fin <= 0;
            if (rst) cyc <= 0;
        end else begin
            acc_done <= 1'b0;
            if (lat != 2'd0 && !(acc_wr || acc_rd)) drop_err <= 1'b1;
            if (acc_rd && !rd_seen) begin rd_seen <= 1'b1; t_rd0 <= cyc; end
            if (acc_wr && acc_addr == 2'd0 && acc_wdata[1:0] == 2'd0 && !fin_seen) begin
                fin_seen <= 1'b1; t_fin <= cyc;
            end
            if ((acc_wr || acc_rd) && !acc_done) begin
                if (lat == 2'd1) begin
                    lat <= 2'd0;
                    acc_done <= 1'b1;
                    if (acc_rd) begin
                        acc_ok    <= !(cur.rdfail != 0 && rd_n + 1 == int'(cur.rdfail));
                        acc_rdata <= mk_status(rd_n + 1);
                        rd_n      <= rd_n + 1;
                        t_lastrd  <= cyc;
                    end else if (acc_addr == 2'd1) begin
                        drv_last <= acc_wdata;
                        if (drv_n == 0) t_drv0 <= cyc;
                        drv_n <= drv_n + 1;
                    end else begin
                        pat_last <= acc_wdata[1:0];
                        if (acc_wdata[1:0] >= 2'd2) eqpat_log <= acc_wdata[1:0];
                        if (!first_pat_seen) begin
                            first_pat_seen <= 1'b1;
                            first_pat <= acc_wdata[1:0];
                            src_at_first <= src_pattern;
                        end
                    end
                end else begin
                    lat <= lat + 2'd1;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        cur = v; lane_cnt = v.lanes; tps3_ok = v.tps3; log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!train_done) @(negedge clk);
        chk("R6/R7/R8 clock recovery result", 32'(cr_ok), 32'(v.exp_cr));
        chk("R9/R10/R11 equalization result", 32'(eq_ok), 32'(v.exp_eq));
        chk("R8/R10/R11 status read count", 32'(rd_n), 32'(v.exp_reads));
        chk("R9 equalization pattern", 32'(eqpat_log), 32'(v.exp_eqpat));
        chk("R4/R5 last drive word", 32'(drv_last), 32'({4{v.exp_drv}}));
        chk("R5 source drive matches", 32'({src_pre, src_swing}), 32'({v.exp_drv[4:3], v.exp_drv[1:0]}));
        chk("R3 first sink pattern", 32'({first_pat, src_at_first}), 32'({2'd1, 2'd1}));
        chk("R3 first poll delay", 32'((t_rd0 - t_drv0) >= SETTLE + POLL), 32'd1);
        chk("R12 sink pattern off", 32'(pat_last), 32'd0);
        chk("R12 source pattern off", 32'({busy, src_pattern}), 32'd0);
        chk("R12 finish settle delay", 32'((t_fin - t_lastrd) >= SETTLE), 32'd1);
        chk("R2 request held until done", 32'(drop_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status outputs", 32'({busy, train_done, cr_ok, eq_ok}), 32'd0);
        chk("R1 source outputs", 32'({src_pattern, src_swing, src_pre}), 32'd0);
        chk("R1 no requests", 32'({acc_wr, acc_rd}), 32'd0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R12 results hold while idle
        run_vec(VECS[4]);
        repeat (30) @(negedge clk);
        chk("R12 results held", 32'({train_done, cr_ok, eq_ok}), 32'b110);

        // R12 start clears previous results
        @(negedge clk);
        cur = VECS[2]; lane_cnt = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 start clears results", 32'({train_done, cr_ok, eq_ok, busy}), 32'b0001);
        while (!train_done) @(negedge clk);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule